// File: doc/BRIEF.md
# Interrupt Acknowledge Opcode Jammer

This block sits on the peripheral side of a processor's general vectored interrupt line. When the peripheral logic pulses a start input, the block captures a service configuration, raises its request and holds it until the processor has answered. The processor answers with one or more active-low acknowledge strobes. During each strobe the block places one byte on the 8-bit data bus.

In restart mode a single strobe receives a one-byte restart opcode built from a 3-bit code. The processor then branches to code×8 (code 1 goes to 0x0008, code 7 to 0x0038). In call mode three strobes receive, in order, the call opcode 0xCD, the low byte of a 16-bit service-routine address and then its high byte. Outside a strobe the bus enable is low, so the pad can be tri-stated. Once the last byte of the selected mode has been delivered, the request is withdrawn. The acknowledge strobe is sampled on the block clock, and each strobe ends at its rising edge.

Top module: `intr_jam`

## Requirements
- R1: After reset, intr_o is 0, data_oe_o is 0 and data_o is 0x00.
- R2: A start_i pulse while idle sets intr_o from the next clock edge. intr_o then stays high until the final strobe of the sequence has ended.
- R3: In restart mode (mode_i = 0) the single strobe drives 11NNN111, where NNN is code_i. Codes 0 to 7 give 0xC7, 0xCF, 0xD7, 0xDF, 0xE7, 0xEF, 0xF7 and 0xFF.
- R4: In call mode (mode_i = 1) the first, second and third strobes drive 0xCD, addr_i[7:0] and addr_i[15:8], in that order.
- R5: data_oe_o is high only while inta_ni is low and a request is pending. When data_oe_o is low, data_o is 0x00.
- R6: intr_o falls at the first clock edge after the rising edge of the final strobe. The final strobe is the first one in restart mode and the third one in call mode. It stays high after an earlier strobe.
- R7: An acknowledge strobe with no request pending is ignored: the bus stays released, and a later request starts from its first byte.
- R8: start_i while a request is pending is ignored. The captured mode, code and address stay in force until that sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse from the peripheral logic |
| mode_i | input | 1 | 0 = restart opcode, 1 = call with address |
| code_i | input | 3 | Restart code NNN |
| addr_i | input | 16 | Service-routine address for call mode |
| inta_ni | input | 1 | Acknowledge strobe from the processor, active low |
| intr_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Byte driven onto the data bus |
| data_oe_o | output | 1 | Bus drive enable; the pad is high impedance when low |

## Verification
The bench builds the block with its default parameters: a 3-bit restart code, a 16-bit address and call opcode 0xCD. With those values, all eight restart encodings can be swept directly, and random addresses confirm the byte order in call mode. Random sequences mix the two modes and insert idle gaps. Directed cases cover a strobe with no request pending and a start pulse in the middle of a sequence, and they check the cycle in which the request drops.

// File: rtl/intr_jam_pkg.sv
package intr_jam_pkg;
  localparam int CODE_W = 3;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic {
    MODE_RST  = 1'b0,
    MODE_CALL = 1'b1
  } jam_mode_e;

  typedef struct packed {
    jam_mode_e         mode;
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
  } jam_cfg_t;

  function automatic logic [BYTE_W-1:0] restart_opcode(input logic [CODE_W-1:0] code);
    return {2'b11, code, 3'b111};
  endfunction
endpackage

// File: rtl/intr_jam_seq.sv
module intr_jam_seq
  import intr_jam_pkg::*;
#(
  parameter int CALL_BYTES = 3,
  localparam int IDX_W = $clog2(CALL_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  jam_cfg_t         cfg_i,
  input  logic             inta_ni,
  output logic             pending_o,
  output logic [IDX_W-1:0] idx_o,
  output jam_cfg_t         cfg_o
);
  logic             inta_q, pending_q, rise;
  logic [IDX_W-1:0] idx_q, last_idx;
  jam_cfg_t         cfg_q;

  // a strobe ends on the rising edge of inta_ni; it counts only while a request is pending
  assign rise     = pending_q & inta_ni & ~inta_q;
  assign last_idx = (cfg_q.mode == MODE_CALL) ? IDX_W'(CALL_BYTES-1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inta_q    <= 1'b1;
      pending_q <= 1'b0;
      idx_q     <= '0;
      cfg_q     <= '0;
    end else begin
      inta_q <= inta_ni;
      if (!pending_q) begin
        if (start_i) begin
          pending_q <= 1'b1;
          cfg_q     <= cfg_i;
          idx_q     <= '0;
        end
      end else if (rise) begin
        if (idx_q == last_idx) begin
          pending_q <= 1'b0;
          idx_q     <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign pending_o = pending_q;
  assign idx_o     = idx_q;
  assign cfg_o     = cfg_q;

  p_drop_after_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pending_q) |-> $past(rise));
  p_cfg_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && $past(pending_q)) |-> $stable(cfg_q));
  p_hold_request_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !rise) |=> pending_q);
endmodule

// File: rtl/intr_jam_byte_sel.sv
module intr_jam_byte_sel
  import intr_jam_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CALL_OPC = 8'hCD,
  parameter int IDX_W = 2
) (
  input  jam_cfg_t          cfg_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int N_ADDR_BYTES = ADDR_W / BYTE_W;

  logic [BYTE_W-1:0] call_bytes [N_ADDR_BYTES+1];

  assign call_bytes[0] = CALL_OPC;
  for (genvar g = 0; g < N_ADDR_BYTES; g++) begin : g_addr_bytes
    assign call_bytes[g+1] = cfg_i.addr[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = restart_opcode(cfg_i.code);
    if (cfg_i.mode == MODE_CALL) begin
      byte_o = '0;
      for (int i = 0; i <= N_ADDR_BYTES; i++) begin
        if (int'(idx_i) == i) byte_o = call_bytes[i];
      end
    end
  end
endmodule

// File: rtl/intr_jam.sv
module intr_jam
  import intr_jam_pkg::*;
#(
  parameter logic [7:0] CALL_OPC = 8'hCD
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        mode_i,
  input  logic [2:0]  code_i,
  input  logic [15:0] addr_i,
  input  logic        inta_ni,
  output logic        intr_o,
  output logic [7:0]  data_o,
  output logic        data_oe_o
);
  localparam int CALL_BYTES = 1 + ADDR_W / BYTE_W;
  localparam int IDX_W      = $clog2(CALL_BYTES);

  jam_cfg_t          cfg_in, cfg_q;
  logic              pending;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] sel_byte;

  assign cfg_in = '{mode: jam_mode_e'(mode_i), code: code_i, addr: addr_i};

  intr_jam_seq #(.CALL_BYTES(CALL_BYTES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cfg_i    (cfg_in),
    .inta_ni  (inta_ni),
    .pending_o(pending),
    .idx_o    (idx),
    .cfg_o    (cfg_q)
  );

  intr_jam_byte_sel #(.CALL_OPC(CALL_OPC), .IDX_W(IDX_W)) u_sel (
    .cfg_i (cfg_q),
    .idx_i (idx),
    .byte_o(sel_byte)
  );

  assign intr_o    = pending;
  assign data_oe_o = pending & ~inta_ni;
  assign data_o    = data_oe_o ? sel_byte : '0;

  p_drive_in_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!inta_ni && intr_o));
  p_quiet_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == 8'h00));
  p_restart_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && cfg_q.mode == MODE_RST) |-> (data_o[7:6] == 2'b11 && data_o[2:0] == 3'b111));
endmodule

// File: tb/intr_jam_tb_top.sv
module intr_jam_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [2:0]  code = '0;
  logic [15:0] addr = '0;
  logic        inta_n = 1'b1;
  logic        intr;
  logic [7:0]  data;
  logic        oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  intr_jam dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .code_i(code), .addr_i(addr), .inta_ni(inta_n),
    .intr_o(intr), .data_o(data), .data_oe_o(oe)
  );

  function automatic logic [7:0] exp_byte(input logic m, input logic [2:0] c,
                                          input logic [15:0] a, input int k);
    if (!m) return {2'b11, c, 3'b111};
    case (k)
      0:       return 8'hCD;
      1:       return a[7:0];
      default: return a[15:8];
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input logic m, input logic [2:0] c, input logic [15:0] a);
    @(negedge clk);
    mode = m; code = c; addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 intr raised", 32'(intr), 32'd1);
  endtask

  // one strobe: low across one edge, sample mid-strobe, release, then settle one edge
  task automatic strobe(output logic [7:0] b, output logic e);
    @(negedge clk);
    inta_n = 1'b0;
    #1;
    b = data; e = oe;
    @(negedge clk);
    inta_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_seq(input logic m, input logic [2:0] c, input logic [15:0] a);
    logic [7:0] b;
    logic e;
    int nb;
    nb = m ? 3 : 1;
    request(m, c, a);
    for (int k = 0; k < nb; k++) begin
      strobe(b, e);
      check("R5 oe during strobe", 32'(e), 32'd1);
      check(m ? "R4 call byte" : "R3 restart byte", 32'(b), 32'(exp_byte(m, c, a, k)));
      check("R6 intr after strobe", 32'(intr), (k == nb-1) ? 32'd0 : 32'd1);
      check("R5 bus released", 32'(oe), 32'd0);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic e;
    logic [31:0] seed;
    seed = $urandom(32'h5A17);
    #1;
    check("R1 intr reset", 32'(intr), 32'd0);
    check("R1 oe reset", 32'(oe), 32'd0);
    check("R1 data reset", 32'(data), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 spurious strobe
    strobe(b, e);
    check("R7 spurious oe", 32'(e), 32'd0);
    check("R7 spurious data", 32'(b), 32'd0);
    check("R7 no request", 32'(intr), 32'd0);
    run_seq(1'b1, 3'd0, 16'hBEEF);

    // R3 all restart codes
    for (int c = 0; c < 8; c++) run_seq(1'b0, 3'(c), 16'h0000);

    // R8 start mid-sequence
    request(1'b1, 3'd2, 16'h1234);
    strobe(b, e);
    check("R4 first", 32'(b), 32'hCD);
    @(negedge clk);
    mode = 1'b0; code = 3'd5; addr = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    strobe(b, e);
    check("R8 low byte kept", 32'(b), 32'h34);
    strobe(b, e);
    check("R8 high byte kept", 32'(b), 32'h12);
    check("R8 intr dropped", 32'(intr), 32'd0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic m;
      logic [2:0] c;
      logic [15:0] a;
      m = 1'($urandom);
      c = 3'($urandom);
      a = 16'($urandom);
      run_seq(m, c, a);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule